// File: doc/BRIEF.md
# Asynchronous Octet-Stuffed HDLC Transmitter

This block turns a stream of payload bytes into HDLC-like frames on an asynchronous serial line. A frame opens with a flag octet, carries the payload with transparency escaping, appends a 16-bit frame check sequence and closes with a second flag. Every octet on the wire is framed as a start bit, eight data bits and a stop bit. The line bit time comes from a 16x timing tick, which is either divided down from the system clock or taken from an external 16x clock pin.

Payload enters on a valid/ready byte interface; the last byte of a frame is marked. The source must hold `s_valid`, `s_data` and `s_last` steady until a cycle where `s_valid` and `s_ready` are both high. That cycle consumes the byte. The block holds `s_ready` low whenever it cannot take a byte: while it sends flags, escape octets or the check sequence, while a character is still on the line, and while the far end withholds clear-to-send. Control pins (`baud_sel`, `map_en`, `cts_n`) are plain levels. `baud_sel` and `map_en` should only change between frames.

Top module: `async_hdlc_tx`

## Requirements
- R1: Each frame begins and ends with the flag octet 0x7E. A frame only starts once `s_valid` is seen, and between characters and frames `txd` rests at 1.
- R2: Inside a frame, the payload or check octets 0x7E and 0x7D are each sent as the pair 0x7D, (octet XOR 0x20).
- R3: With `map_en` = 1, every payload or check octet below 0x20 is escaped in the same way as R2. With `map_en` = 0 such octets go out unchanged. The octet 0x20 itself is never escaped.
- R4: Each octet leaves as a 0 start bit, then data bits 0 to 7 (least significant first), then a 1 stop bit.
- R5: The check sequence is computed over the unescaped payload only. It uses the reflected polynomial 0x8408 with preset 0xFFFF, and the result is complemented. It is sent low byte first and is itself escaped. For the payload "123456789" its two octets are 0x6E then 0x90.
- R6: When `cts_n` goes high, the character already started finishes and no new character starts until `cts_n` is low again. No octet is lost or repeated.
- R7: One line bit lasts 16 timing ticks. The internal tick divisor for rate B is floor((SYS_HZ + 8B) / (16B)). `baud_sel` selects B as follows: 110 = 115200, 101 = 57600, 100 = 38400, 011 = 28800, 010 = 19200, 001 = 14400, 000 = 9600.
- R8: With `baud_sel` = 111, each rising edge of `ext_x16` is one timing tick.
- R9: `s_ready` is high only while `s_valid` is high inside a frame's payload phase. A byte is consumed exactly on a cycle with both high, and the byte marked `s_last` ends the payload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_sel | input | 3 | Rate select code (R7, R8) |
| ext_x16 | input | 1 | External 16x timing clock, asynchronous |
| map_en | input | 1 | Escape all octets below 0x20 when 1 |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| s_valid | input | 1 | Payload byte valid |
| s_data | input | 8 | Payload byte |
| s_last | input | 1 | Marks final payload byte of a frame |
| s_ready | output | 1 | Payload byte accepted this cycle when high with s_valid |
| txd | output | 1 | Serial line output, idles high |

## Verification
Every cycle, the bound checker checks four things. The line is high whenever no character is in flight. `txd` moves only on a timing tick or a character load. No character starts while clear-to-send is withheld. `s_ready` never rises without `s_valid`. It also checks that the octet offered to the serializer stays put until it is taken. The bench scenarios cover the rest: the full octet order of a frame, escaping under both map settings, the check-sequence value, the measured bit length at several internal rates and under the external clock, and the pause-and-resume order around a clear-to-send drop. Those depend on whole frames decoded off the line.

// File: rtl/ahdlc_pkg.sv
package ahdlc_pkg;
  localparam logic [7:0]  FLAG_OCTET  = 8'h7E;
  localparam logic [7:0]  ESC_OCTET   = 8'h7D;
  localparam logic [7:0]  ESC_FLIP    = 8'h20;
  localparam logic [7:0]  CTRL_BOUND  = 8'h20;
  localparam logic [15:0] FCS_POLY    = 16'h8408;
  localparam logic [15:0] FCS_PRESET  = 16'hFFFF;
  localparam logic [2:0]  EXT_CODE    = 3'b111;

  typedef enum logic [2:0] {
    FR_IDLE, FR_OPEN, FR_BODY, FR_FCS_LO, FR_FCS_HI, FR_CLOSE
  } frame_state_t;

  // One octet through the reflected CRC-16 register, bit 0 first.
  function automatic logic [15:0] fcs_next(input logic [15:0] cur, input logic [7:0] octet);
    logic [15:0] r;
    r = cur;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ octet[i]) r = (r >> 1) ^ FCS_POLY;
      else                 r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic must_escape(input logic [7:0] octet, input logic ctl_map);
    return (octet == FLAG_OCTET) || (octet == ESC_OCTET) || (ctl_map && (octet < CTRL_BOUND));
  endfunction

  function automatic int unsigned line_rate(input logic [2:0] code);
    int unsigned r;
    case (code)
      3'b110:  r = 115200;
      3'b101:  r = 57600;
      3'b100:  r = 38400;
      3'b011:  r = 28800;
      3'b010:  r = 19200;
      3'b001:  r = 14400;
      default: r = 9600;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ahdlc_baud_gen.sv
module ahdlc_baud_gen
  import ahdlc_pkg::*;
#(
  parameter int unsigned SYS_HZ     = 50_000_000,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       ext_x16,
  output logic       tick
);
  localparam int unsigned SLOWEST = 9600;
  localparam int unsigned MAX_DIV = (SYS_HZ + SLOWEST * OVERSAMPLE / 2) / (SLOWEST * OVERSAMPLE);
  localparam int unsigned DIV_W   = $clog2(MAX_DIV + 2);

  logic [DIV_W-1:0] div_tab [8];

  for (genvar g = 0; g < 7; g++) begin : g_rate
    localparam int unsigned RATE = line_rate(3'(g));
    localparam int unsigned RAW  = (SYS_HZ + RATE * OVERSAMPLE / 2) / (RATE * OVERSAMPLE);
    localparam int unsigned DIV  = (RAW == 0) ? 1 : RAW;
    assign div_tab[g] = DIV_W'(DIV);
  end
  assign div_tab[7] = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             int_tick;
  logic [2:0]       ext_q;
  logic             ext_tick;

  assign lim      = div_tab[sel] - 1'b1;
  assign int_tick = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (int_tick) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= '0;
    else        ext_q <= {ext_q[1:0], ext_x16};
  end

  assign ext_tick = ext_q[1] & ~ext_q[2];
  assign tick     = (sel == EXT_CODE) ? ext_tick : int_tick;
endmodule

// File: rtl/ahdlc_framer.sv
module ahdlc_framer
  import ahdlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       map_en,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       s_ready,
  output logic       o_valid,
  output logic [7:0] o_byte,
  input  logic       o_ready
);
  frame_state_t st;
  logic         esc_ph;
  logic [15:0]  crc;
  logic [15:0]  fcs;
  logic [7:0]   raw;
  logic         raw_ok;
  logic         stuffable;
  logic         esc_need;
  logic         hs;
  logic         done_byte;

  assign fcs = ~crc;

  always_comb begin
    raw    = FLAG_OCTET;
    raw_ok = 1'b0;
    case (st)
      FR_OPEN, FR_CLOSE: raw_ok = 1'b1;
      FR_BODY:   begin raw = s_data;    raw_ok = s_valid; end
      FR_FCS_LO: begin raw = fcs[7:0];  raw_ok = 1'b1;    end
      FR_FCS_HI: begin raw = fcs[15:8]; raw_ok = 1'b1;    end
      default: ;
    endcase
  end

  assign stuffable = (st == FR_BODY) || (st == FR_FCS_LO) || (st == FR_FCS_HI);
  assign esc_need  = stuffable && must_escape(raw, map_en);
  assign o_valid   = raw_ok;
  assign o_byte    = !esc_need ? raw : (esc_ph ? (raw ^ ESC_FLIP) : ESC_OCTET);
  assign hs        = o_valid && o_ready;
  assign done_byte = hs && (!esc_need || esc_ph);
  assign s_ready   = (st == FR_BODY) && done_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= FR_IDLE;
      esc_ph <= 1'b0;
      crc    <= FCS_PRESET;
    end else begin
      case (st)
        FR_IDLE: if (s_valid) begin
          st     <= FR_OPEN;
          crc    <= FCS_PRESET;
          esc_ph <= 1'b0;
        end
        FR_OPEN:  if (hs) st <= FR_BODY;
        FR_CLOSE: if (hs) st <= FR_IDLE;
        default: begin
          if (hs && esc_need && !esc_ph) esc_ph <= 1'b1;
          if (done_byte) begin
            esc_ph <= 1'b0;
            case (st)
              FR_BODY: begin
                crc <= fcs_next(crc, s_data);
                if (s_last) st <= FR_FCS_LO;
              end
              FR_FCS_LO: st <= FR_FCS_HI;
              default:   st <= FR_CLOSE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ahdlc_serializer.sv
module ahdlc_serializer #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cts_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  output logic              in_ready,
  output logic              busy,
  output logic              hold,
  output logic              load,
  output logic              txd
);
  localparam int unsigned FRAME_BITS = DATA_W + 2;
  localparam int unsigned BIT_W      = $clog2(FRAME_BITS);
  localparam int unsigned OS_W       = $clog2(OVERSAMPLE);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [OS_W-1:0]  LAST_OS  = OS_W'(OVERSAMPLE - 1);

  logic [FRAME_BITS-1:0] shreg;
  logic [BIT_W-1:0]      bit_idx;
  logic [OS_W-1:0]       os_cnt;
  logic [1:0]            cts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cts_q <= 2'b11;
    else        cts_q <= {cts_q[0], cts_n};
  end

  assign hold     = cts_q[1];
  assign in_ready = !busy && !hold;
  assign load     = in_valid && in_ready;
  assign txd      = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      shreg   <= '1;
      bit_idx <= '0;
      os_cnt  <= '0;
    end else if (!busy) begin
      if (load) begin
        shreg   <= {1'b1, in_byte, 1'b0};
        busy    <= 1'b1;
        bit_idx <= '0;
        os_cnt  <= '0;
      end
    end else if (tick) begin
      if (os_cnt == LAST_OS) begin
        os_cnt <= '0;
        shreg  <= {1'b1, shreg[FRAME_BITS-1:1]};
        if (bit_idx == LAST_BIT) busy <= 1'b0;
        else                     bit_idx <= bit_idx + 1'b1;
      end else begin
        os_cnt <= os_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/async_hdlc_tx.sv
module async_hdlc_tx #(
  parameter int unsigned SYS_HZ     = 50_000_000,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] baud_sel,
  input  logic       ext_x16,
  input  logic       map_en,
  input  logic       cts_n,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       s_ready,
  output logic       txd
);
  logic       line_tick;
  logic       oct_valid;
  logic [7:0] oct_byte;
  logic       oct_ready;
  logic       ser_busy;
  logic       ser_hold;
  logic       ser_load;

  ahdlc_baud_gen #(.SYS_HZ(SYS_HZ), .OVERSAMPLE(OVERSAMPLE)) u_baud (
    .clk(clk), .rst_n(rst_n), .sel(baud_sel), .ext_x16(ext_x16), .tick(line_tick)
  );

  ahdlc_framer u_framer (
    .clk(clk), .rst_n(rst_n), .map_en(map_en),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .o_valid(oct_valid), .o_byte(oct_byte), .o_ready(oct_ready)
  );

  ahdlc_serializer #(.DATA_W(8), .OVERSAMPLE(OVERSAMPLE)) u_ser (
    .clk(clk), .rst_n(rst_n), .tick(line_tick), .cts_n(cts_n),
    .in_valid(oct_valid), .in_byte(oct_byte), .in_ready(oct_ready),
    .busy(ser_busy), .hold(ser_hold), .load(ser_load), .txd(txd)
  );
endmodule

// File: rtl/async_hdlc_tx_props.sv
module async_hdlc_tx_props (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       load,
  input logic       busy,
  input logic       hold,
  input logic       txd,
  input logic       s_valid,
  input logic       s_ready,
  input logic       o_valid,
  input logic       o_ready,
  input logic [7:0] o_byte
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_octet_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_byte)));

  assert_cts_blocks_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !busy) |=> !busy);

  assert_line_moves_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(txd));

  assert_ready_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> s_valid);
endmodule

bind async_hdlc_tx async_hdlc_tx_props u_props (
  .clk(clk), .rst_n(rst_n), .tick(line_tick), .load(ser_load), .busy(ser_busy),
  .hold(ser_hold), .txd(txd), .s_valid(s_valid), .s_ready(s_ready),
  .o_valid(oct_valid), .o_ready(oct_ready), .o_byte(oct_byte)
);

// File: tb/async_hdlc_tx_test.sv
module async_hdlc_tx_test;
  localparam int unsigned SYS_HZ   = 3_686_400;
  localparam int          EXT_HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] baud_sel = 3'b111;
  logic       ext_x16 = 1'b0;
  logic       map_en = 1'b0;
  logic       cts_n = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic       txd;

  async_hdlc_tx #(.SYS_HZ(SYS_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .baud_sel(baud_sel), .ext_x16(ext_x16), .map_en(map_en),
    .cts_n(cts_n), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .txd(txd)
  );

  always #10 clk = ~clk;

  initial forever begin
    repeat (EXT_HALF) @(posedge clk);
    ext_x16 = ~ext_x16;
  end

  int checks = 0;
  int errors = 0;
  int bit_cyc = 16 * 2 * EXT_HALF;
  logic [7:0] pay [64];
  int pay_n;
  logic [7:0] exp_w [160];
  int exp_n;
  logic [7:0] rx_buf [160];
  int rx_cnt = 0;
  int stop_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // line monitor: decodes characters off txd
  initial forever begin
    logic [7:0] d;
    @(negedge txd);
    repeat (bit_cyc / 2) @(negedge clk);
    if (txd == 1'b0) begin
      for (int b = 0; b < 8; b++) begin
        repeat (bit_cyc) @(negedge clk);
        d[b] = txd;
      end
      repeat (bit_cyc) @(negedge clk);
      if (txd !== 1'b1) stop_err++;
      rx_buf[rx_cnt] = d;
      rx_cnt++;
    end
  end

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, pay[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  task automatic push_w(input logic [7:0] b, input bit stuff, input bit mp);
    if (stuff && (b == 8'h7E || b == 8'h7D || (mp && b < 8'h20))) begin
      exp_w[exp_n] = 8'h7D;      exp_n++;
      exp_w[exp_n] = b ^ 8'h20;  exp_n++;
    end else begin
      exp_w[exp_n] = b;          exp_n++;
    end
  endtask

  task automatic build_expected(input bit mp);
    logic [15:0] f;
    exp_n = 0;
    push_w(8'h7E, 1'b0, mp);
    for (int i = 0; i < pay_n; i++) push_w(pay[i], 1'b1, mp);
    f = ~ref_crc(pay_n);
    push_w(f[7:0], 1'b1, mp);
    push_w(f[15:8], 1'b1, mp);
    push_w(8'h7E, 1'b0, mp);
  endtask

  task automatic drive_frame(input int gap);
    for (int i = 0; i < pay_n; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = pay[i]; s_last = (i == pay_n - 1);
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      s_valid = 1'b0; s_last = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic wait_and_compare(input string tag);
    int t = 0;
    while (rx_cnt < exp_n && t < 60000) begin @(negedge clk); t++; end
    repeat (2 * bit_cyc) @(negedge clk);
    chk(rx_cnt == exp_n, {tag, " octet count"}, rx_cnt, exp_n);
    for (int i = 0; i < exp_n && i < rx_cnt; i++)
      chk(rx_buf[i] == exp_w[i], tag, rx_buf[i], exp_w[i]);
    chk(stop_err == 0, "R4 stop bit high", stop_err, 0);
    chk(txd == 1'b1, "R1 line idle after frame", txd, 1);
  endtask

  task automatic run_frame(input bit mp, input int gap, input string tag);
    map_en = mp;
    rx_cnt = 0;
    build_expected(mp);
    drive_frame(gap);
    wait_and_compare(tag);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 txd high after reset", txd, 1);
    chk(s_ready == 1'b0, "R9 no ready without valid", s_ready, 0);
  endtask

  task automatic t_plain;
    pay[0] = 8'h01; pay[1] = 8'h41; pay[2] = 8'h42; pay_n = 3;
    run_frame(1'b0, 0, "R1 R4 R8 plain frame");
  endtask

  task automatic t_escape;
    pay[0] = 8'h7E; pay[1] = 8'h55; pay[2] = 8'h7D; pay[3] = 8'h5E; pay_n = 4;
    run_frame(1'b0, 0, "R2 flag/escape stuffing");
  endtask

  task automatic t_map;
    pay[0] = 8'h00; pay[1] = 8'h1F; pay[2] = 8'h20; pay[3] = 8'h41; pay_n = 4;
    run_frame(1'b1, 0, "R3 map on escapes controls");
    chk(exp_w[1] == 8'h7D && exp_w[2] == 8'h20, "R3 0x00 escaped (model)", exp_w[2], 8'h20);
    run_frame(1'b0, 0, "R3 map off sends controls raw");
    chk(rx_buf[1] == 8'h00 && rx_buf[3] == 8'h20, "R3 raw controls on line", rx_buf[1], 8'h00);
  endtask

  task automatic t_crc_vector;
    for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
    pay_n = 9;
    run_frame(1'b0, 0, "R5 check sequence frame");
    chk(rx_buf[10] == 8'h6E, "R5 fcs low octet", rx_buf[10], 8'h6E);
    chk(rx_buf[11] == 8'h90, "R5 fcs high octet", rx_buf[11], 8'h90);
  endtask

  task automatic t_backpressure;
    pay[0] = 8'hA5; pay[1] = 8'h7E; pay[2] = 8'h3C; pay_n = 3;
    run_frame(1'b0, 37, "R9 gapped source");
  endtask

  task automatic t_cts;
    int t = 0;
    int bad = 0;
    for (int i = 0; i < 8; i++) pay[i] = 8'h11 + 8'(i);
    pay_n = 8;
    map_en = 1'b0;
    rx_cnt = 0;
    build_expected(1'b0);
    fork
      drive_frame(0);
    join_none
    while (rx_cnt < 2) @(negedge clk);
    @(negedge txd);
    repeat (10) @(negedge clk);
    cts_n = 1'b1;
    while (rx_cnt < 3 && t < 20 * bit_cyc) begin @(negedge clk); t++; end
    repeat (bit_cyc) @(negedge clk);
    for (int i = 0; i < 30 * bit_cyc; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    chk(rx_cnt == 3, "R6 in-flight char completes then pauses", rx_cnt, 3);
    chk(bad == 0, "R6 line idle while held", bad, 0);
    cts_n = 1'b0;
    wait_and_compare("R6 frame intact after resume");
  endtask

  task automatic t_rate(input logic [2:0] code, input int rate);
    int dv = (SYS_HZ + rate * 8) / (rate * 16);
    int lowc = 0;
    bit_cyc = 16 * dv;
    baud_sel = code;
    map_en = 1'b0;
    pay[0] = 8'h5A; pay_n = 1;
    rx_cnt = 0;
    build_expected(1'b0);
    fork
      drive_frame(0);
    join_none
    @(negedge txd);
    while (txd == 1'b0) begin @(negedge clk); lowc++; end
    // start bit plus bit 0 of the flag: two bit times, first one up to one tick short
    chk(lowc >= 2 * bit_cyc - dv - 2 && lowc <= 2 * bit_cyc + 2,
        "R7 internal bit length", lowc, 2 * bit_cyc);
    wait_and_compare("R7 frame at internal rate");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_escape();
    t_map();
    t_crc_vector();
    t_backpressure();
    t_cts();
    t_rate(3'b110, 115200);
    t_rate(3'b101, 57600);
    t_rate(3'b000, 9600);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule